// File: doc/BRIEF.md
# Event Counter Bank with Sticky Overflow Flags

The block holds eight 32-bit event counters behind a word-addressed register port. Each counter carries an enable bit in a shared mode register and an 8-bit source select field. The field names which of the eight event inputs lets the counter advance, or none at all. Software enables a counter, points it at an event input, and then reads or reloads its value through the same port.

When a counter wraps from all ones to zero, it raises a sticky flag in the overflow status register. Software clears a flag by writing a one to its bit. A wrap that lands on the same edge as a clear wins, so no overflow can be lost. A level interrupt stays high while any flag is set.

Register offsets (byte addresses, word aligned): mode 0x00, status 0x10, select words 0x20 and 0x24, counter values 0x40 + 4*n. Offsets that are not mapped read as zero and ignore writes. Reads are combinational from `addr_i`. Writes take effect on the rising clock edge where `wr_en_i` is high.

Top module: `evt_cnt_bank`

## Requirements
- R1: Counter n (0 to 7) is a 32-bit value that reads and writes at offset 0x40 + 4*n, and it resets to 0.
- R2: The status register at 0x10 shows the flag of counter n in bit n (bits 7:0), and bits 31:8 always read as zero.
- R3: Overflow flags reset to 0 and stay set until a write to 0x10 has a 1 in that bit position; writing 0 to a bit leaves it unchanged.
- R4: If a counter wraps on the same edge as a write that clears its flag, the flag is set after that edge.
- R5: `irq_o` is high exactly while at least one overflow flag is set, and it goes low only when all flags are clear.
- R6: The mode register at 0x00 holds the enable of counter n in bit n and resets to 0; a counter whose enable is 0 holds its value.
- R7: The select field of counter n is 8 bits wide. Counters 0 to 3 use bits 8*n+7:8*n of the word at 0x20, and counters 4 to 7 use bits 8*(n-4)+7:8*(n-4) of the word at 0x24. Every field resets to 0xFF.
- R8: An enabled counter whose select value s is in 0..7 advances by exactly one on each edge where event input s is high.
- R9: A select value of 0xFF, or any value of 8 or more, never lets the counter advance.
- R10: A counter that advances from 0xFFFFFFFF goes to 0 and sets its overflow flag on that same edge.
- R11: A write to a counter value is loaded on that edge, takes priority over an increment on the same edge, and does not set the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| evt_i | input | 8 | Event inputs, one per source |
| irq_o | output | 1 | Level interrupt, any overflow flag set |

## Verification
A wrong increment condition shows up in the counter value one edge after the event pulse. The bench therefore steps a one-hot event across every input, for every counter and several select codes, and expects exactly one hit or none. A flag that is lost or kept too long is visible in the status readback and on `irq_o` right after the edge in question. The same-edge cases are driven on one edge each: a wrap against a clear, and a load against an increment, so a wrong priority changes the value read back on the very next cycle.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam logic [ADDR_W-1:0] MODE_OFS = 8'h00;
  localparam logic [ADDR_W-1:0] STAT_OFS = 8'h10;
  localparam logic [ADDR_W-1:0] SEL_OFS  = 8'h20;
  localparam logic [ADDR_W-1:0] CNT_OFS  = 8'h40;
endpackage

// File: rtl/evt_cnt_unit.sv
module evt_cnt_unit #(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned SEL_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               ld_i,
  input  logic [CNT_W-1:0]   ld_val_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               wrap_o
);
  localparam int unsigned IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             sel_ok;
  logic             inc;

  assign sel_ok = (sel_i < SEL_W'(NUM_EVT));
  assign inc    = en_i && sel_ok && evt_i[sel_i[IDX_W-1:0]];
  // a load on the same edge wins, so no wrap is reported
  assign wrap_o = inc && !ld_i && (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (ld_i) cnt_q <= ld_val_i;
    else if (inc)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_load_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> cnt_q == $past(ld_val_i));
  p_halt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !ld_i) |=> $stable(cnt_q));
  p_bad_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_ok && !ld_i) |=> $stable(cnt_q));
  p_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sel_ok && evt_i[sel_i[IDX_W-1:0]] && !ld_i) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/evt_ovf_status.sv
module evt_ovf_status #(
  parameter int unsigned NUM_CNT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CNT-1:0] set_i,
  input  logic [NUM_CNT-1:0] clr_i,
  output logic [NUM_CNT-1:0] flags_o,
  output logic               irq_o
);
  logic [NUM_CNT-1:0] flags_q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |flags_q;

  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));
  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(flags_q) & ~$past(clr_i) & ~flags_q) == '0));
  p_no_spurious_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(set_i)) == '0));
endmodule

// File: rtl/evt_cnt_regs.sv
module evt_cnt_regs
  import evt_cnt_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned SEL_W   = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [NUM_CNT-1:0]            mode_o,
  output logic [NUM_CNT-1:0][SEL_W-1:0] sel_o,
  output logic [NUM_CNT-1:0]            stat_clr_o,
  output logic [NUM_CNT-1:0]            cnt_we_o,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val_i,
  input  logic [NUM_CNT-1:0]            flags_i
);
  localparam int unsigned FPW       = DATA_W / SEL_W;
  localparam int unsigned SEL_WORDS = (NUM_CNT + FPW - 1) / FPW;

  logic [NUM_CNT-1:0]            mode_q;
  logic [NUM_CNT-1:0][SEL_W-1:0] sel_q;
  logic                          mode_we;
  logic [SEL_WORDS-1:0]          sel_we;

  assign mode_we    = wr_en_i && (addr_i == MODE_OFS);
  assign stat_clr_o = (wr_en_i && (addr_i == STAT_OFS)) ? wdata_i[NUM_CNT-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= '0;
    else if (mode_we) mode_q <= wdata_i[NUM_CNT-1:0];
  end

  for (genvar w = 0; w < SEL_WORDS; w++) begin : g_sel_word
    assign sel_we[w] = wr_en_i && (addr_i == ADDR_W'(SEL_OFS + 4*w));
    for (genvar f = 0; f < FPW; f++) begin : g_field
      if (w*FPW + f < NUM_CNT) begin : g_live
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)        sel_q[w*FPW+f] <= '1;
          else if (sel_we[w]) sel_q[w*FPW+f] <= wdata_i[f*SEL_W +: SEL_W];
        end
      end
    end
  end

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt_we
    assign cnt_we_o[n] = wr_en_i && (addr_i == ADDR_W'(CNT_OFS + 4*n));
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == MODE_OFS) rdata_o[NUM_CNT-1:0] = mode_q;
    if (addr_i == STAT_OFS) rdata_o[NUM_CNT-1:0] = flags_i;
    for (int w = 0; w < SEL_WORDS; w++) begin
      if (addr_i == ADDR_W'(SEL_OFS + 4*w)) begin
        rdata_o = '1;
        for (int f = 0; f < FPW; f++)
          if (w*FPW + f < NUM_CNT) rdata_o[f*SEL_W +: SEL_W] = sel_q[w*FPW+f];
      end
    end
    for (int n = 0; n < NUM_CNT; n++)
      if (addr_i == ADDR_W'(CNT_OFS + 4*n)) rdata_o[CNT_W-1:0] = cnt_val_i[n];
  end

  assign mode_o = mode_q;
  assign sel_o  = sel_q;

  p_mode_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we |=> mode_o == $past(wdata_i[NUM_CNT-1:0]));
  p_one_cnt_we_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cnt_we_o));
endmodule

// File: rtl/evt_cnt_bank.sv
module evt_cnt_bank
  import evt_cnt_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned SEL_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_CNT-1:0] evt_i,
  output logic               irq_o
);
  logic [NUM_CNT-1:0]            mode;
  logic [NUM_CNT-1:0][SEL_W-1:0] sel;
  logic [NUM_CNT-1:0]            stat_clr;
  logic [NUM_CNT-1:0]            cnt_we;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;
  logic [NUM_CNT-1:0]            wrap;
  logic [NUM_CNT-1:0]            flags;

  evt_cnt_regs #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .mode_o(mode), .sel_o(sel), .stat_clr_o(stat_clr), .cnt_we_o(cnt_we),
    .cnt_val_i(cnt_val), .flags_i(flags)
  );

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    evt_cnt_unit #(.NUM_EVT(NUM_CNT), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_unit (
      .clk_i, .rst_ni,
      .en_i(mode[n]), .sel_i(sel[n]), .evt_i(evt_i),
      .ld_i(cnt_we[n]), .ld_val_i(wdata_i[CNT_W-1:0]),
      .cnt_o(cnt_val[n]), .wrap_o(wrap[n])
    );
  end

  evt_ovf_status #(.NUM_CNT(NUM_CNT)) u_status (
    .clk_i, .rst_ni, .set_i(wrap), .clr_i(stat_clr), .flags_o(flags), .irq_o
  );

  p_irq_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_en_i && (addr_i == STAT_OFS)));
  p_irq_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|evt_i));
endmodule

// File: tb/evt_cnt_bank_tb.sv
module evt_cnt_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  evt = 8'h00;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  evt_cnt_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  // write with event pattern held for the same single edge
  task automatic wr_with_evt(input logic [7:0] a, input logic [31:0] d, input logic [7:0] e);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; evt = e;
    @(negedge clk);
    wr_en = 1'b0; evt = 8'h00;
  endtask

  task automatic pulse(input logic [7:0] e, input int cyc);
    @(negedge clk);
    evt = e;
    repeat (cyc) @(negedge clk);
    evt = 8'h00;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd("R6", 8'h00, 32'h0);
    rd("R3", 8'h10, 32'h0);
    rd("R7", 8'h20, 32'hFFFF_FFFF);
    rd("R7", 8'h24, 32'hFFFF_FFFF);
    for (int n = 0; n < 8; n++) rd("R1", 8'(8'h40 + 4*n), 32'h0);
    chk("R5", {31'b0, irq}, 32'h0);
    rd("R1", 8'h30, 32'h0);

    // load and read back every counter
    for (int n = 0; n < 8; n++) wr(8'(8'h40 + 4*n), 32'hA500_0000 | 32'(n * 32'h0101));
    for (int n = 0; n < 8; n++) rd("R1", 8'(8'h40 + 4*n), 32'hA500_0000 | 32'(n * 32'h0101));

    // select sweep: every counter, several select codes, one-hot event walk
    for (int n = 0; n < 8; n++) begin
      for (int si = 0; si < 10; si++) begin
        logic [7:0]  s;
        logic [31:0] word;
        s = (si < 8) ? 8'(si) : ((si == 8) ? 8'h1F : 8'hFF);
        word = 32'hFFFF_FFFF;
        word[(n % 4)*8 +: 8] = s;
        wr(8'(8'h20 + 4*(n / 4)), word);
        if (si == 0) rd("R7", 8'(8'h20 + 4*(n / 4)), word);
        wr(8'h00, 32'(1 << n));
        wr(8'(8'h40 + 4*n), 32'h0);
        for (int k = 0; k < 8; k++) pulse(8'(1 << k), 1);
        if (si < 8) rd("R8", 8'(8'h40 + 4*n), 32'h1);
        else        rd("R9", 8'(8'h40 + 4*n), 32'h0);
      end
    end
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);

    // enable gating on counter 2
    wr(8'h20, 32'hFF02_FFFF);
    wr(8'h00, 32'h0);
    rd("R6", 8'h00, 32'h0);
    wr(8'h48, 32'd7);
    pulse(8'hFF, 4);
    rd("R6", 8'h48, 32'd7);
    wr(8'h00, 32'h0000_0004);
    pulse(8'hFF, 4);
    rd("R8", 8'h48, 32'd11);

    // wrap sets flag
    wr(8'h48, 32'hFFFF_FFFE);
    pulse(8'h04, 2);
    rd("R10", 8'h48, 32'h0);
    rd("R10", 8'h10, 32'h4);
    chk("R5", {31'b0, irq}, 32'h1);

    // zero writes and reserved bits leave flags alone
    wr(8'h10, 32'hFFFF_FF00);
    rd("R2", 8'h10, 32'h4);
    wr(8'h10, 32'h0);
    rd("R3", 8'h10, 32'h4);

    // wrap against clear on the same edge
    wr(8'h48, 32'hFFFF_FFFF);
    wr_with_evt(8'h10, 32'h4, 8'h04);
    rd("R4", 8'h10, 32'h4);
    rd("R4", 8'h48, 32'h0);
    chk("R4", {31'b0, irq}, 32'h1);

    // plain clear
    wr(8'h10, 32'h4);
    rd("R3", 8'h10, 32'h0);
    chk("R5", {31'b0, irq}, 32'h0);

    // load beats increment
    wr(8'h48, 32'd50);
    wr_with_evt(8'h48, 32'd100, 8'h04);
    rd("R11", 8'h48, 32'd100);
    wr(8'h48, 32'hFFFF_FFFF);
    wr_with_evt(8'h48, 32'd5, 8'h04);
    rd("R11", 8'h48, 32'd5);
    rd("R11", 8'h10, 32'h0);
    chk("R11", {31'b0, irq}, 32'h0);

    // two flags, interrupt until both cleared
    wr(8'h20, 32'hFFFF_FF00);
    wr(8'h24, 32'hFFFF_05FF);
    wr(8'h00, 32'h0000_0021);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h54, 32'hFFFF_FFFF);
    pulse(8'h21, 1);
    rd("R2", 8'h10, 32'h21);
    chk("R5", {31'b0, irq}, 32'h1);
    wr(8'h10, 32'h01);
    rd("R3", 8'h10, 32'h20);
    chk("R5", {31'b0, irq}, 32'h1);
    wr(8'h10, 32'h20);
    rd("R3", 8'h10, 32'h0);
    chk("R5", {31'b0, irq}, 32'h0);

    report();
  end
endmodule